// File: doc/BRIEF.md
# Three-Phase Gate Signal Crossover and Masking Stage

This stage sits between a three-phase PWM timing generator and the six gate-drive pins of an inverter. Each phase has a high-side and a low-side signal. For each phase, the stage can exchange the two signals, which is called crossover. It can then hold any single pin in its OFF state. All signals are active low, so OFF is a logic high.

A typical use is commutation of a brushless DC motor. Only two inverter legs conduct at a time. Crossover lets one duty value switch the high side of one leg and the low side of another leg together. Masking keeps the third leg idle.

Software writes a 9-bit control word into a staging input. The stage copies that word into an active register only on PWM cycle boundaries. A boundary is the rising edge of the sync strobe. When double-update mode is selected, the rising edge of the midpoint strobe is also a boundary. Only the active copy steers the signals, and all six pins are registered. Changes to the staging word between boundaries therefore never reach the pins.

Top module: `pwm_xg_top`

## Requirements
- R1: While reset is asserted, all six pins are high (OFF). After reset, the active control word is zero, so no pair is crossed over and no pin is masked.
- R2: Each pin is registered. A change on the raw inputs appears on the pins one clock later.
- R3: Control bit 8 crosses over phase A. Raw A-high then drives the A-low pin, and raw A-low drives the A-high pin.
- R4: Control bit 7 crosses over phase B in the same way, and control bit 6 crosses over phase C.
- R5: Control bits 5..0 mask the pins in this order: A-low, A-high, B-low, B-high, C-low, C-high. While its bit is set in the active word, the pin is held high, whatever the raw signal.
- R6: Masking is applied after crossover. A mask bit refers to the pin, not to the raw signal that the pin carries.
- R7: The staging word is copied into the active word only on a clock where a rising edge of sync is seen. Any other change to the staging word leaves the pins unaffected.
- R8: When double-update mode is off, the midpoint strobe has no effect.
- R9: When double-update mode is on, a rising edge of the midpoint strobe also loads the staging word.
- R10: Loads trigger on edges, not levels. While sync is held high, later changes to the staging word are not loaded.
- R11: Active word 0x0A7 crosses over phase B and masks A-low, B-high, C-high and C-low. With equal raw A-high and B-high inputs, the A-high and B-low pins are identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_hi | input | 3 | Raw high-side signals from the timing generator, index 0=A, 1=B, 2=C (active low) |
| raw_lo | input | 3 | Raw low-side signals, same indexing (active low) |
| ctrl_wr | input | 9 | Staging control word: bit 8..6 crossover A..C, bits 5..0 pin masks |
| sync_in | input | 1 | PWM cycle-start strobe; its rising edge loads the active word |
| mid_in | input | 1 | PWM midpoint strobe; its rising edge loads only in double-update mode |
| dbl_mode | input | 1 | 1 selects double-update mode |
| pin_hi | output | 3 | Registered high-side gate pins A..C (active low) |
| pin_lo | output | 3 | Registered low-side gate pins A..C (active low) |

## Verification
Several properties are checked by assertions on every cycle. The active word stays stable when no boundary edge is seen. The midpoint strobe has no effect outside double-update mode. A masked pin is high on the next cycle. An uncrossed, unmasked pin follows its own raw signal one cycle later. Other behaviour only shows up when the bench's reference model is compared against the pins under directed scenarios. That includes exact swap routing per phase, masking applied after crossover, edge-only loading while sync is held high, and the identical A-high and B-low waveforms under 0x0A7.

// File: rtl/pwm_xg_pkg.sv
package pwm_xg_pkg;
  localparam int NPAIR = 3;
  localparam int CW    = 3 + 2 * NPAIR;
  localparam int XBASE = 2 * NPAIR;

  // crossover bit of pair p (A=0 at the top bit)
  function automatic int xbit(input int p);
    return CW - 1 - p;
  endfunction

  // mask bit of the high-side pin of pair p
  function automatic int mhi_bit(input int p);
    return XBASE - 2 - 2 * p;
  endfunction

  // mask bit of the low-side pin of pair p
  function automatic int mlo_bit(input int p);
    return XBASE - 1 - 2 * p;
  endfunction
endpackage

// File: rtl/pwm_xg_shadow.sv
module pwm_xg_shadow
  import pwm_xg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ctrl_wr,
  input  logic          sync_in,
  input  logic          mid_in,
  input  logic          dbl_mode,
  output logic [CW-1:0] act_q,
  output logic          load_evt
);
  logic sync_d, mid_d;
  logic sync_rise, mid_rise;

  assign sync_rise = sync_in & ~sync_d;
  assign mid_rise  = mid_in & ~mid_d;
  assign load_evt  = sync_rise | (dbl_mode & mid_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d <= 1'b0;
      mid_d  <= 1'b0;
      act_q  <= '0;
    end else begin
      sync_d <= sync_in;
      mid_d  <= mid_in;
      if (load_evt) act_q <= ctrl_wr;
    end
  end

  // R7
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_in && !mid_in) |=> $stable(act_q));

  // R8
  mid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbl_mode && !sync_in) |=> $stable(act_q));
endmodule

// File: rtl/pwm_xg_cross.sv
module pwm_xg_cross
  import pwm_xg_pkg::*;
(
  input  logic [CW-1:0]    act,
  input  logic [NPAIR-1:0] raw_hi,
  input  logic [NPAIR-1:0] raw_lo,
  output logic [NPAIR-1:0] x_hi,
  output logic [NPAIR-1:0] x_lo
);
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int XB = xbit(p);
    assign x_hi[p] = act[XB] ? raw_lo[p] : raw_hi[p];
    assign x_lo[p] = act[XB] ? raw_hi[p] : raw_lo[p];
  end
endmodule

// File: rtl/pwm_xg_gate.sv
module pwm_xg_gate
  import pwm_xg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    act,
  input  logic [NPAIR-1:0] x_hi,
  input  logic [NPAIR-1:0] x_lo,
  output logic [NPAIR-1:0] pin_hi,
  output logic [NPAIR-1:0] pin_lo
);
  logic [NPAIR-1:0] m_hi, m_lo;

  for (genvar p = 0; p < NPAIR; p++) begin : g_mask
    localparam int HB = mhi_bit(p);
    localparam int LB = mlo_bit(p);
    assign m_hi[p] = act[HB];
    assign m_lo[p] = act[LB];

    // R5
    mask_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act[HB] |=> pin_hi[p]);
    // R5
    mask_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act[LB] |=> pin_lo[p]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_hi <= '1;
      pin_lo <= '1;
    end else begin
      pin_hi <= x_hi | m_hi;
      pin_lo <= x_lo | m_lo;
    end
  end
endmodule

// File: rtl/pwm_xg_top.sv
module pwm_xg_top
  import pwm_xg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] raw_hi,
  input  logic [NPAIR-1:0] raw_lo,
  input  logic [CW-1:0]    ctrl_wr,
  input  logic             sync_in,
  input  logic             mid_in,
  input  logic             dbl_mode,
  output logic [NPAIR-1:0] pin_hi,
  output logic [NPAIR-1:0] pin_lo
);
  logic [CW-1:0]    act_q;
  logic             load_evt;
  logic [NPAIR-1:0] x_hi, x_lo;

  pwm_xg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .sync_in(sync_in),
    .mid_in(mid_in), .dbl_mode(dbl_mode), .act_q(act_q), .load_evt(load_evt)
  );

  pwm_xg_cross u_cross (
    .act(act_q), .raw_hi(raw_hi), .raw_lo(raw_lo), .x_hi(x_hi), .x_lo(x_lo)
  );

  pwm_xg_gate u_gate (
    .clk(clk), .rst_n(rst_n), .act(act_q), .x_hi(x_hi), .x_lo(x_lo),
    .pin_hi(pin_hi), .pin_lo(pin_lo)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_chk
    // R2
    straight_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_q[xbit(p)] && !act_q[mhi_bit(p)]) |=> (pin_hi[p] == $past(raw_hi[p])));
    // R4
    swap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q[xbit(p)] && !act_q[mlo_bit(p)]) |=> (pin_lo[p] == $past(raw_hi[p])));
  end
endmodule

// File: tb/sim_pwm_xg_top.sv
module sim_pwm_xg_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] raw_hi = 3'b111, raw_lo = 3'b111;
  logic [8:0] ctrl_wr = '0;
  logic       sync_in = 1'b0, mid_in = 1'b0, dbl_mode = 1'b0;
  logic [2:0] pin_hi, pin_lo;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_xg_top u0 (
    .clk(clk), .rst_n(rst_n), .raw_hi(raw_hi), .raw_lo(raw_lo),
    .ctrl_wr(ctrl_wr), .sync_in(sync_in), .mid_in(mid_in),
    .dbl_mode(dbl_mode), .pin_hi(pin_hi), .pin_lo(pin_lo)
  );

  // behavioural reference
  int mact = 0, ms_prev = 0, mm_prev = 0;
  int exp_hi = 7, exp_lo = 7;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mact = 0; ms_prev = 0; mm_prev = 0; exp_hi = 7; exp_lo = 7;
    end else begin
      int nh, nl;
      nh = 0; nl = 0;
      for (int p = 0; p < 3; p++) begin
        int h, l, t;
        h = raw_hi[p]; l = raw_lo[p];
        if ((mact >> (8 - p)) & 1) begin t = h; h = l; l = t; end
        if ((mact >> (4 - 2 * p)) & 1) h = 1;
        if ((mact >> (5 - 2 * p)) & 1) l = 1;
        nh += h << p; nl += l << p;
      end
      exp_hi = nh; exp_lo = nl;
      if ((sync_in && ms_prev == 0) || (dbl_mode && mid_in && mm_prev == 0))
        mact = ctrl_wr;
      ms_prev = sync_in; mm_prev = mid_in;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(cur_req, pin_hi, exp_hi, "pin_hi");
    check(cur_req, pin_lo, exp_lo, "pin_lo");
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      raw_hi = $urandom; raw_lo = $urandom;
    end
  endtask

  task automatic strobe_sync();
    @(posedge clk); #1; sync_in = 1'b1;
    @(posedge clk); #1; sync_in = 1'b0;
  endtask

  task automatic strobe_mid();
    @(posedge clk); #1; mid_in = 1'b1;
    @(posedge clk); #1; mid_in = 1'b0;
  endtask

  task automatic load(input logic [8:0] w);
    @(posedge clk); #1; ctrl_wr = w;
    strobe_sync();
  endtask

  initial begin
    void'($urandom(7));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", pin_hi, 7, "reset pin_hi");
    check("R1", pin_lo, 7, "reset pin_lo");
    rst_n = 1'b1;
    cur_req = "R2"; step(20);
    // R7 staging write without sync is ignored
    cur_req = "R7"; ctrl_wr = 9'h03F; step(12);
    @(negedge clk); checks++;
    if (pin_hi == 3'b111 && pin_lo == 3'b111 && (raw_hi != 7 || raw_lo != 7)) begin
      fails++; $display("FAIL R7 pins all masked before sync actual=%0h expected=unmasked", {pin_hi, pin_lo});
    end
    cur_req = "R3"; load(9'h100); step(16);
    cur_req = "R4"; load(9'h0C0); step(16);
    cur_req = "R5";
    for (int b = 0; b < 6; b++) begin load(9'(1 << b)); step(8); end
    cur_req = "R6"; load(9'h1FF & 9'h1C5); step(16);
    // R11 example word with equal A and B high raw signals
    cur_req = "R11"; load(9'h0A7);
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1;
      raw_hi[0] = $urandom; raw_hi[1] = raw_hi[0];
      raw_hi[2] = $urandom; raw_lo = $urandom;
      @(negedge clk);
      if (i > 0) check("R11", pin_hi[0], pin_lo[1], "AH vs BL");
    end
    // R8 midpoint ignored in single mode
    cur_req = "R8"; @(posedge clk); #1; ctrl_wr = 9'h111; strobe_mid(); step(10);
    // R9 double mode midpoint loads
    cur_req = "R9"; dbl_mode = 1'b1; @(posedge clk); #1; ctrl_wr = 9'h14A; strobe_mid(); step(10);
    @(posedge clk); #1; ctrl_wr = 9'h000; strobe_sync(); step(10);
    dbl_mode = 1'b0;
    // R10 held sync loads once
    cur_req = "R10"; @(posedge clk); #1; ctrl_wr = 9'h0C3; sync_in = 1'b1;
    step(3); ctrl_wr = 9'h13C; step(12); sync_in = 1'b0; step(6);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1; checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule